// File: doc/BRIEF.md
# LCD Frame and Palette Load Sequencer

This block drives the load side of an LCD controller. When software raises the enable, the sequencer fetches a colour lookup table and/or frame words from an upstream word source. A mode field selects one of three fetch plans: lookup table only, frame only, or lookup table first and then frame. Lookup-table words fill an internal 256-entry memory of 12-bit colours. The first word of the table also carries a code that gives the pixel depth. Frame words pass through a small FIFO and leave as pixels whenever the timing side signals that a pixel is due.

Dropping the enable does not cut the picture. A frame in flight runs on until the timing side reports its end. Only then does the block go idle and report completion. Six status bits record errors and events, and each bit has its own clearing rule. An interrupt line combines the status bits through per-bit mask inputs. The DMA engine and the timing generator sit outside the block and appear only as request/valid and pulse ports.

Top module: `lcd_load_seq`

## Requirements
- R1: From idle, a high `cfg_enable` starts a run on the next clock and latches `cfg_mode`. Mode 1 (table only) and mode 2 (table then frame) begin with `req_pal` high. Mode 0 and mode 3 begin with `req_frm`. `req_pal` and `req_frm` are never high together, and `req_pal` is high only while `cfg_enable` is high. A word is taken in any cycle where a request and `src_valid` are both high.
- R2: `src_data[15:12]` of the first table word of a run is the depth code. `pal_bpp` reports 1, 2, 4, 8 and 16 for codes 0, 1, 2, 3 and 4, and 0 for codes 5 to 15. Its value after reset is 0.
- R3: A table is 129 words long when its depth code is 0 to 3, and 9 words for any other code. `req_pal` falls in the cycle after the last word is taken.
- R4: Table word w writes `src_data[11:0]` to entry 2w and `src_data[27:16]` to entry 2w+1. Entries numbered 256 and above are dropped. `lut_rgb` shows entry `lut_addr` in the same cycle.
- R5: In mode 1 the block makes no frame requests after the table ends and waits for the enable to fall. In mode 2 it moves straight on to frame fetch.
- R6: During frame fetch, `req_frm` is high while the FIFO (4 words by default) has room. When `tg_pix_due` is high and the FIFO is not empty, `pix_valid` is high in that same cycle and `pix_data` gives the oldest word. Words come out in the order they were taken.
- R7: Status bit 0 (underflow) sets when a pixel is due during frame fetch, the FIFO is empty and the enable is high. Status bit 1 (sync lost) sets on `tg_sync_err` in any active state while enabled. Both bits clear on the clock after any cycle with the enable low, and no other input clears them.
- R8: If the enable falls during frame fetch, fetch and pixel output go on until a `tg_frame_end` pulse. The block then goes idle and the FIFO is emptied. If the enable falls while the table is loading or while mode 1 is waiting, the block goes idle at once.
- R9: Status bit 2 (done) sets when the block returns to idle, but only if `cfg_irq_mask[2]` is high in that cycle. It clears only when a new run starts.
- R10: Status bit 3 (vsync) and bit 4 (line) set on `tg_vsync` and `tg_line` pulses during frame fetch. A 1 in the matching bit of `sts_clr` clears them, and a new event in the same cycle wins over the clear.
- R11: Status bit 5 (table loaded) sets when the last table word is taken. If the latched mode is 1, a 1 in `sts_clr[5]` clears it. In any other mode, `sts_clr[5]` has no effect and the bit clears on the clock after any cycle with the enable low.
- R12: `irq` is high exactly when some status bit and its `cfg_irq_mask` bit are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Run enable; low requests a graceful stop |
| cfg_mode | input | 2 | Fetch plan: 0 frame, 1 table only, 2 table then frame, 3 frame |
| cfg_irq_mask | input | 6 | Per-status-bit interrupt mask |
| sts_clr | input | 6 | Write-one-to-clear strobes for status bits 3, 4 and 5 |
| src_valid | input | 1 | Upstream word valid |
| src_data | input | 32 | Upstream word |
| req_pal | output | 1 | Requesting table words |
| req_frm | output | 1 | Requesting frame words |
| tg_pix_due | input | 1 | Timing side wants a pixel word this cycle |
| tg_vsync | input | 1 | Vertical sync pulse |
| tg_line | input | 1 | Line interrupt pulse |
| tg_frame_end | input | 1 | End of the current frame |
| tg_sync_err | input | 1 | Timing side lost sync |
| pix_valid | output | 1 | Pixel word delivered this cycle |
| pix_data | output | 32 | Pixel word |
| lut_addr | input | 8 | Lookup table read index |
| lut_rgb | output | 12 | Lookup table colour at `lut_addr` |
| pal_bpp | output | 5 | Decoded pixel depth |
| status | output | 6 | Status bits: underflow, sync lost, done, vsync, line, table loaded |
| irq | output | 1 | Masked interrupt |

## Verification
The request lines, `pix_valid`, `pix_data`, `lut_rgb` and `irq` follow the current state and the current inputs within the same cycle. A change of state, a status bit or `pal_bpp` caused by inputs present at a clock edge shows up right after that edge. Stimulus is applied on the falling edge. Two time units later, every output is compared with a behavioural model, which updates on each rising edge from the inputs that were held stable across it. Because of this, each result is checked in the first cycle it is due and in every cycle after.

// File: rtl/lcdl_pkg.sv
package lcdl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PAL   = 2'd1,
    ST_FRAME = 2'd2,
    ST_HOLD  = 2'd3
  } run_st_t;

  // status bit positions
  localparam int unsigned S_UNDER = 0;
  localparam int unsigned S_SYNC  = 1;
  localparam int unsigned S_DONE  = 2;
  localparam int unsigned S_VSYNC = 3;
  localparam int unsigned S_LINE  = 4;
  localparam int unsigned S_PAL   = 5;
  localparam int unsigned NSTAT   = 6;

  // fetch plans
  localparam logic [1:0] MODE_FRAME = 2'd0;
  localparam logic [1:0] MODE_PAL   = 2'd1;
  localparam logic [1:0] MODE_BOTH  = 2'd2;

  // table length in words for a depth code
  function automatic int pal_word_count(input logic [3:0] code,
                                        input int long_words,
                                        input int short_words);
    return (code <= 4'd3) ? long_words : short_words;
  endfunction

  // depth code to bits per pixel; unknown codes give 0
  function automatic logic [4:0] code_to_bpp(input logic [3:0] code);
    logic [4:0] r;
    case (code)
      4'd0:    r = 5'd1;
      4'd1:    r = 5'd2;
      4'd2:    r = 5'd4;
      4'd3:    r = 5'd8;
      4'd4:    r = 5'd16;
      default: r = 5'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lcdl_fifo.sv
module lcdl_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign dout  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underread_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/lcdl_palette.sv
module lcdl_palette #(
  parameter int LUT_AW          = 8,
  parameter int PAL_BYTES_LONG  = 512,
  parameter int PAL_BYTES_SHORT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              wr,
  input  logic [27:0]       wdata,
  output logic              last,
  output logic [4:0]        bpp,
  input  logic [LUT_AW-1:0] rd_addr,
  output logic [11:0]       rd_rgb
);
  import lcdl_pkg::*;

  localparam int LONG_W  = PAL_BYTES_LONG / 4 + 1;
  localparam int SHORT_W = PAL_BYTES_SHORT / 4 + 1;
  localparam int CW      = $clog2(LONG_W + 1);
  localparam int IDXW    = CW + 1;
  localparam int LUT_N   = 1 << LUT_AW;

  logic [11:0]     mem [LUT_N];
  logic [CW-1:0]   cnt_q;
  logic [3:0]      code_q;
  logic [3:0]      code_eff;
  logic [IDXW-1:0] idx;
  logic            in_range;

  assign code_eff = (cnt_q == '0) ? wdata[15:12] : code_q;
  assign last     = wr && ((int'(cnt_q) + 1) == pal_word_count(code_eff, LONG_W, SHORT_W));
  assign idx      = {cnt_q, 1'b0};
  assign in_range = int'(idx) < LUT_N;
  assign bpp      = code_to_bpp(code_q);
  assign rd_rgb   = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr && in_range) begin
      mem[idx[LUT_AW-1:0]]          <= wdata[11:0];
      mem[{idx[LUT_AW-1:1], 1'b1}] <= wdata[27:16];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      code_q <= 4'hF;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (wr) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '0) code_q <= wdata[15:12];
    end
  end

  assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (int'(cnt_q) < LONG_W));

endmodule

// File: rtl/lcdl_status.sv
module lcdl_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       restart,
  input  logic       pal_only,
  input  logic       done_allowed,
  input  logic       ev_under,
  input  logic       ev_sync,
  input  logic       ev_done,
  input  logic       ev_vsync,
  input  logic       ev_line,
  input  logic       ev_pal,
  input  logic [5:0] clr,
  output logic [5:0] stat
);
  import lcdl_pkg::*;

  logic [5:0] stat_q;
  assign stat = stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      // error bits: only a disable clears them
      stat_q[S_UNDER] <= enable && (stat_q[S_UNDER] || ev_under);
      stat_q[S_SYNC]  <= enable && (stat_q[S_SYNC] || ev_sync);
      // completion: cleared by the next run start
      stat_q[S_DONE]  <= !restart && (stat_q[S_DONE] || (ev_done && done_allowed));
      // event bits: write one to clear, new event wins
      stat_q[S_VSYNC] <= (stat_q[S_VSYNC] && !clr[S_VSYNC]) || ev_vsync;
      stat_q[S_LINE]  <= (stat_q[S_LINE] && !clr[S_LINE]) || ev_line;
      // table loaded: clear rule depends on the running plan
      if (pal_only) stat_q[S_PAL] <= (stat_q[S_PAL] && !clr[S_PAL]) || ev_pal;
      else          stat_q[S_PAL] <= enable && (stat_q[S_PAL] || ev_pal);
    end
  end

  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (stat_q[S_UNDER] == 1'b0 && stat_q[S_SYNC] == 1'b0));
  assert_done_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !stat_q[S_DONE]);
  assert_vsync_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[S_VSYNC] && !clr[S_VSYNC]) |=> stat_q[S_VSYNC]);

endmodule

// File: rtl/lcd_load_seq.sv
module lcd_load_seq #(
  parameter int WORD_W          = 32,
  parameter int FIFO_DEPTH      = 4,
  parameter int LUT_AW          = 8,
  parameter int PAL_BYTES_LONG  = 512,
  parameter int PAL_BYTES_SHORT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_mode,
  input  logic [5:0]        cfg_irq_mask,
  input  logic [5:0]        sts_clr,
  input  logic              src_valid,
  input  logic [WORD_W-1:0] src_data,
  output logic              req_pal,
  output logic              req_frm,
  input  logic              tg_pix_due,
  input  logic              tg_vsync,
  input  logic              tg_line,
  input  logic              tg_frame_end,
  input  logic              tg_sync_err,
  output logic              pix_valid,
  output logic [WORD_W-1:0] pix_data,
  input  logic [LUT_AW-1:0] lut_addr,
  output logic [11:0]       lut_rgb,
  output logic [4:0]        pal_bpp,
  output logic [5:0]        status,
  output logic              irq
);
  import lcdl_pkg::*;

  run_st_t    st_q, st_d;
  logic [1:0] run_mode_q;

  // named internal events
  logic start_evt, pal_take, frm_take, pal_last, frame_stop, abort_evt, done_evt;
  logic due_ok, pop_evt, under_evt, sync_evt, vs_evt, line_evt;
  logic fifo_empty, fifo_full;

  assign start_evt  = (st_q == ST_IDLE) && cfg_enable;
  assign req_pal    = (st_q == ST_PAL) && cfg_enable;
  assign req_frm    = (st_q == ST_FRAME) && !fifo_full;
  assign pal_take   = req_pal && src_valid;
  assign frm_take   = req_frm && src_valid;
  assign frame_stop = (st_q == ST_FRAME) && !cfg_enable && tg_frame_end;
  assign abort_evt  = ((st_q == ST_PAL) || (st_q == ST_HOLD)) && !cfg_enable;
  assign done_evt   = frame_stop || abort_evt;
  assign due_ok     = (st_q == ST_FRAME) && tg_pix_due;
  assign pop_evt    = due_ok && !fifo_empty;
  assign under_evt  = due_ok && fifo_empty && cfg_enable;
  assign sync_evt   = (st_q != ST_IDLE) && cfg_enable && tg_sync_err;
  assign vs_evt     = (st_q == ST_FRAME) && tg_vsync;
  assign line_evt   = (st_q == ST_FRAME) && tg_line;
  assign pix_valid  = pop_evt;
  assign irq        = |(status & cfg_irq_mask);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (cfg_enable)
                  st_d = ((cfg_mode == MODE_PAL) || (cfg_mode == MODE_BOTH)) ? ST_PAL : ST_FRAME;
      ST_PAL:   if (!cfg_enable)  st_d = ST_IDLE;
                else if (pal_last) st_d = (run_mode_q == MODE_PAL) ? ST_HOLD : ST_FRAME;
      ST_FRAME: if (frame_stop)   st_d = ST_IDLE;
      ST_HOLD:  if (!cfg_enable)  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      run_mode_q <= MODE_FRAME;
    end else begin
      st_q <= st_d;
      if (start_evt) run_mode_q <= cfg_mode;
    end
  end

  lcdl_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(frm_take), .din(src_data), .pop(pop_evt),
    .flush(frame_stop), .dout(pix_data), .empty(fifo_empty), .full(fifo_full)
  );

  lcdl_palette #(.LUT_AW(LUT_AW), .PAL_BYTES_LONG(PAL_BYTES_LONG),
                 .PAL_BYTES_SHORT(PAL_BYTES_SHORT)) u_pal (
    .clk(clk), .rst_n(rst_n), .restart(start_evt), .wr(pal_take),
    .wdata(src_data[27:0]), .last(pal_last), .bpp(pal_bpp),
    .rd_addr(lut_addr), .rd_rgb(lut_rgb)
  );

  lcdl_status u_stat (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .restart(start_evt),
    .pal_only(run_mode_q == MODE_PAL), .done_allowed(cfg_irq_mask[S_DONE]),
    .ev_under(under_evt), .ev_sync(sync_evt), .ev_done(done_evt),
    .ev_vsync(vs_evt), .ev_line(line_evt), .ev_pal(pal_last),
    .clr(sts_clr), .stat(status)
  );

  assert_single_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_pal && req_frm));
  assert_hold_no_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD) |-> !req_frm);
  assert_done_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[S_DONE]) |-> $past(cfg_irq_mask[S_DONE]));
  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_FRAME) && !tg_frame_end) |=> (st_q == ST_FRAME));

endmodule

// File: tb/sim_lcd_load_seq.sv
module sim_lcd_load_seq;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [5:0]  cfg_irq_mask = 6'h3F;
  logic [5:0]  sts_clr = 6'h0;
  logic        src_valid = 1'b0;
  logic [31:0] src_data = 32'h0;
  logic        req_pal, req_frm, pix_valid, irq;
  logic        tg_pix_due = 1'b0, tg_vsync = 1'b0, tg_line = 1'b0;
  logic        tg_frame_end = 1'b0, tg_sync_err = 1'b0;
  logic [31:0] pix_data;
  logic [7:0]  lut_addr = 8'h0;
  logic [11:0] lut_rgb;
  logic [4:0]  pal_bpp;
  logic [5:0]  status;

  lcd_load_seq #(.FIFO_DEPTH(DEPTH)) u0 (.*);

  always #4 clk = ~clk; // 125 MHz

  int checks = 0, errors = 0, cyc = 0;
  bit supply = 0, due_on = 0, finished = 0;
  logic [3:0] hdr_code = 4'd3;

  // behavioural reference state
  int m_st = 0, m_run = 0, m_cnt = 0, m_code = 15;
  bit [5:0] m_stat = 0;
  int m_pal [256];
  bit m_known [256];
  logic [31:0] m_q [$];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int bpp_of(input int c);
    case (c)
      0: return 1; 1: return 2; 2: return 4; 3: return 8; 4: return 16;
      default: return 0;
    endcase
  endfunction

  // random source and pixel demand, driven on the falling edge
  always @(negedge clk) begin
    src_valid <= supply && ($urandom % 4 != 0);
    src_data  <= {$urandom} & 32'hFFFF0FFF | (32'(hdr_code) << 12);
    tg_pix_due <= due_on && ($urandom % 2 == 0);
    lut_addr  <= 8'(cyc * 7);
  end

  // reference model step on the rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_run = 0; m_cnt = 0; m_code = 15; m_stat = 0; m_q.delete();
    end else begin
      bit rp, rf, start, pdone, fstop, abort, due_ok, fuf, sync, vs, ln;
      bit [5:0] ns;
      rp = (m_st == 1) && cfg_enable;
      rf = (m_st == 2) && (m_q.size() < DEPTH);
      start = (m_st == 0) && cfg_enable;
      pdone = 0;
      if (rp && src_valid) begin
        int c, idx;
        c = (m_cnt == 0) ? int'(src_data[15:12]) : m_code;
        if (m_cnt == 0) m_code = c;
        idx = 2 * m_cnt;
        if (idx < 256) begin
          m_pal[idx] = int'(src_data[11:0]);  m_known[idx] = 1;
          m_pal[idx+1] = int'(src_data[27:16]); m_known[idx+1] = 1;
        end
        m_cnt++;
        if (m_cnt == ((c <= 3) ? 129 : 9)) pdone = 1;
      end
      due_ok = (m_st == 2) && tg_pix_due;
      fuf = due_ok && (m_q.size() == 0) && cfg_enable;
      if (due_ok && m_q.size() > 0) void'(m_q.pop_front());
      if (rf && src_valid) m_q.push_back(src_data);
      fstop = (m_st == 2) && !cfg_enable && tg_frame_end;
      abort = ((m_st == 1) || (m_st == 3)) && !cfg_enable;
      sync = (m_st != 0) && cfg_enable && tg_sync_err;
      vs = (m_st == 2) && tg_vsync;
      ln = (m_st == 2) && tg_line;
      ns[0] = cfg_enable && (m_stat[0] || fuf);
      ns[1] = cfg_enable && (m_stat[1] || sync);
      ns[2] = !start && (m_stat[2] || ((fstop || abort) && cfg_irq_mask[2]));
      ns[3] = (m_stat[3] && !sts_clr[3]) || vs;
      ns[4] = (m_stat[4] && !sts_clr[4]) || ln;
      if (m_run == 1) ns[5] = (m_stat[5] && !sts_clr[5]) || pdone;
      else            ns[5] = cfg_enable && (m_stat[5] || pdone);
      m_stat = ns;
      if (start) begin
        m_st = (cfg_mode == 1 || cfg_mode == 2) ? 1 : 2;
        m_run = int'(cfg_mode); m_cnt = 0;
      end else if (m_st == 1) begin
        if (!cfg_enable) m_st = 0;
        else if (pdone) m_st = (m_run == 1) ? 3 : 2;
      end else if (m_st == 2) begin
        if (fstop) begin m_st = 0; m_q.delete(); end
      end else if (m_st == 3) begin
        if (!cfg_enable) m_st = 0;
      end
    end
  end

  // compare every cycle, away from the edges
  always @(negedge clk) begin
    #2;
    cyc++;
    if (cyc > 1 && !finished) begin
      bit epv;
      epv = (m_st == 2) && tg_pix_due && (m_q.size() > 0);
      chk("R1 R3 req_pal", req_pal, (m_st == 1) && cfg_enable);
      chk("R5 R6 R8 req_frm", req_frm, (m_st == 2) && (m_q.size() < DEPTH));
      chk("R6 R8 pix_valid", pix_valid, epv);
      if (epv) chk("R6 pix_data", pix_data, m_q[0]);
      chk("R2 pal_bpp", pal_bpp, bpp_of(m_code));
      if (m_known[lut_addr]) chk("R4 lut_rgb", lut_rgb, m_pal[lut_addr]);
      chk("R7 underflow", status[0], m_stat[0]);
      chk("R7 sync_lost", status[1], m_stat[1]);
      chk("R9 done", status[2], m_stat[2]);
      chk("R10 vsync", status[3], m_stat[3]);
      chk("R10 line", status[4], m_stat[4]);
      chk("R11 pal_loaded", status[5], m_stat[5]);
      chk("R12 irq", irq, |(m_stat & cfg_irq_mask));
    end
    if (cyc > 100000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_st(input int s);
    while (m_st != s) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin m_pal[i] = 0; m_known[i] = 0; end
    tick(3);
    rst_n = 1'b1;
    tick(3); // reset state compared above (R1 R9 R12 at rest)

    // table only, long table (R1 R2 R3 R4 R5 R11)
    cfg_mode = 2'd1; hdr_code = 4'd3; supply = 1; cfg_enable = 1;
    wait_st(3);
    tick(6);
    sts_clr = 6'h20; tick(1); sts_clr = 6'h0; // R11 write clear in table-only plan
    tick(260);                                 // sweep lookup reads (R4)
    cfg_enable = 0; tick(4);                   // R8 immediate stop, R9 done

    // table then frame, short table (R3 R5 R6 R7 R10 R11)
    cfg_mode = 2'd2; hdr_code = 4'd4; cfg_enable = 1; due_on = 1;
    wait_st(2);
    tick(30);
    sts_clr = 6'h20; tick(1); sts_clr = 6'h0;  // R11 no effect here
    tg_vsync = 1; tg_line = 1; tick(1); tg_vsync = 0; tg_line = 0;
    tick(3);
    sts_clr = 6'h08; tick(1); sts_clr = 6'h0;  // R10 clear vsync only
    tg_line = 1; sts_clr = 6'h10; tick(1); tg_line = 0; sts_clr = 6'h0; // R10 set wins
    supply = 0; tick(12); supply = 1;          // R7 underflow
    tg_sync_err = 1; tick(1); tg_sync_err = 0; // R7 sync lost
    tick(10);
    tg_frame_end = 1; tick(1); tg_frame_end = 0; // frame end while enabled: keeps running
    tick(5);
    cfg_enable = 0; tick(15);                  // R8 drain continues
    tg_frame_end = 1; tick(1); tg_frame_end = 0;
    tick(6);

    // frame only with done masked (R9 R12)
    cfg_irq_mask = 6'h3B; cfg_mode = 2'd0; cfg_enable = 1; tick(40);
    cfg_enable = 0; tick(3);
    tg_frame_end = 1; tick(1); tg_frame_end = 0; tick(4);

    // mode 3 runs as frame only (R1)
    cfg_irq_mask = 6'h3F; cfg_mode = 2'd3; cfg_enable = 1; tick(20);
    cfg_enable = 0; tg_frame_end = 1; tick(1); tg_frame_end = 0; tick(3);

    // unknown depth code, aborted mid-table, then a full short table (R2 R3 R8)
    cfg_mode = 2'd2; hdr_code = 4'd9; cfg_enable = 1; tick(4);
    cfg_enable = 0; tick(3);
    cfg_enable = 1; wait_st(2); tick(20);
    due_on = 0; cfg_enable = 0; tick(2);
    tg_frame_end = 1; tick(1); tg_frame_end = 0; tick(4);

    // depth codes 0..2 with table-only plan (R2)
    for (int c = 0; c < 3; c++) begin
      cfg_mode = 2'd1; hdr_code = 4'(c); cfg_enable = 1;
      wait_st(3); tick(2);
      cfg_enable = 0; tick(3);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule